// File: doc/BRIEF.md
# SCSI Controller Interrupt Status Unit

This block holds the status, interrupt and sequence-step registers of a small SCSI host-controller core. From them it drives one level-sensitive interrupt line to the host. The host reaches it through byte-wide register read and write strobes on a 3-bit address. Read data is registered and appears on the cycle after the strobe.

The command engine reports its progress with single-cycle event pulses:
- function complete
- bus service
- disconnect
- bus reset
- transfer count reached zero

The engine also loads the bus-phase field, the sequence step and the FIFO-flags value. A handful of host commands act directly on the interrupt state:
- bus reset
- message accepted
- enable selection
- disable selection
- soft reset

Reading the interrupt register is the acknowledge. It clears that register, the sequence step, the transfer-count status bit and the interrupt line, all in one access.

Register map (address: content):
- 0: status
  - bit 7: interrupt pending (INT)
  - bit 4: transfer count zero (TC)
  - bits 2:0: bus phase
- 1: interrupt, read-to-clear
  - bit 0: function complete
  - bit 1: bus service
  - bit 2: disconnect
  - bit 3: bus reset
- 2: sequence step
- 3: FIFO flags
- 4: command
  - write: opcode in bits 6:0, DMA flag in bit 7
  - read: the last command written
- 5: FIFO data, write only, reads as 0
- 6: configuration 1
  - bit 6 disables bus-reset reporting

Top module: `scsi_irq_status`

## Requirements
- R1: `irq_o` always equals status bit 7. It goes high on any raise source. It stays high until an interrupt-register read (address 1) occurs in a cycle with no raise source.
- R2: A read of address 1 returns the interrupt register's prior value on `reg_rdata_o` one cycle later. The same access zeroes the interrupt register, status bit 4, the sequence step (address 2) and `irq_o`.
- R3: The pulses `ev_fc_i`, `ev_bs_i` and `ev_dc_i` set interrupt bits 0, 1 and 2 and raise the interrupt. A pulse in the same cycle as an address-1 read is kept, not cleared.
- R4: `ev_tc_i` sets status bit 4 without raising the interrupt. It wins over a same-cycle address-1 read.
- R5: The bus-reset command (opcode 0x03) or `ev_busrst_i` sets interrupt bit 3 and raises the interrupt. When configuration bit 6 is set, neither has any effect.
- R6: The disable-selection command (opcode 0x45) zeroes the interrupt register and raises the interrupt. The enable-selection command (opcode 0x44) zeroes the interrupt register and leaves `irq_o` unchanged.
- R7: The message-accepted command (opcode 0x12) sets interrupt bit 2, zeroes the sequence step and the FIFO flags (address 3), and raises the interrupt.
- R8: A write to address 5 sets interrupt bits 0 and 1 and raises the interrupt only while the command register holds exactly 0x10 (non-DMA transfer). With 0x90 in the command register such a write has no effect.
- R9: Hard reset (`rst_ni` low) and the soft-reset command (opcode 0x02) both do the following:
  - zero every register
  - load configuration 1 with 0x07
  - force `irq_o` and `drq_o` low
- R10: `phase_we_i` loads status bits 2:0. `seq_we_i` and `flags_we_i` load addresses 2 and 3. An engine load wins over a same-cycle clear.
- R11: `drq_set_i` drives `drq_o` high and `drq_clr_i` drives it low.
- R12: Configuration 1 (address 6) and the command register (address 4) read back the last byte written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hard reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register byte address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| ev_fc_i | input | 1 | Function-complete event pulse |
| ev_bs_i | input | 1 | Bus-service event pulse |
| ev_dc_i | input | 1 | Disconnect event pulse |
| ev_busrst_i | input | 1 | Bus-reset-seen event pulse |
| ev_tc_i | input | 1 | Transfer-count-zero event pulse |
| phase_we_i | input | 1 | Load bus phase field |
| phase_i | input | 3 | Bus phase code |
| seq_we_i | input | 1 | Load sequence step |
| seq_i | input | 3 | Sequence step value |
| flags_we_i | input | 1 | Load FIFO flags |
| flags_i | input | 5 | FIFO flags value |
| drq_set_i | input | 1 | Assert data request |
| drq_clr_i | input | 1 | Deassert data request |
| irq_o | output | 1 | Level interrupt to host |
| drq_o | output | 1 | Data request line |

## Verification
The assertions assume the following about the inputs:
- A command write and a read never share a cycle.
- Event pulses last one cycle.
- The soft-reset command is never issued in the same cycle as an engine event that it would otherwise have to override.

The stimulus keeps within these limits by driving one host access per falling edge. It overlaps an event with a read only in the cases built to test priority: an event with an interrupt-register read, and a sequence-step load or transfer-count event against the clear. Sweeps cover every combination of the three interrupt events, every phase and sequence code, and both states of the reporting-disable bit.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;
  localparam int unsigned DW = 8;

  localparam logic [2:0] A_STAT  = 3'd0;
  localparam logic [2:0] A_INTR  = 3'd1;
  localparam logic [2:0] A_SEQ   = 3'd2;
  localparam logic [2:0] A_FLAGS = 3'd3;
  localparam logic [2:0] A_CMD   = 3'd4;
  localparam logic [2:0] A_FIFO  = 3'd5;
  localparam logic [2:0] A_CFG1  = 3'd6;

  localparam logic [6:0] OP_RESET  = 7'h02;
  localparam logic [6:0] OP_BUSRST = 7'h03;
  localparam logic [6:0] OP_XFER   = 7'h10;
  localparam logic [6:0] OP_MSGACC = 7'h12;
  localparam logic [6:0] OP_ENSEL  = 7'h44;
  localparam logic [6:0] OP_DISSEL = 7'h45;

  localparam int unsigned IB_FC  = 0;
  localparam int unsigned IB_BS  = 1;
  localparam int unsigned IB_DC  = 2;
  localparam int unsigned IB_RST = 3;
  localparam int unsigned N_IB   = 4;

  localparam int unsigned SB_TC  = 4;
  localparam int unsigned SB_INT = 7;
  localparam int unsigned CFG1_NORPT = 6;
  localparam logic [DW-1:0] CFG1_INIT = 8'h07;

  typedef struct packed {
    logic soft_rst;
    logic bus_rst;
    logic msg_acc;
    logic en_sel;
    logic dis_sel;
    logic fifo_ti;
    logic rd_intr;
  } cmd_evt_t;
endpackage

// File: rtl/scsi_irq_dec.sv
module scsi_irq_dec
  import scsi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [6:0]        op_i,
  input  logic [DW-1:0]     cmd_q_i,
  output cmd_evt_t          evt_o
);
  logic wr_cmd;

  always_comb begin
    evt_o  = '0;
    wr_cmd = reg_wr_i && (reg_addr_i == ADDR_W'(A_CMD));
    if (wr_cmd) begin
      unique case (op_i)
        OP_RESET:  evt_o.soft_rst = 1'b1;
        OP_BUSRST: evt_o.bus_rst  = 1'b1;
        OP_MSGACC: evt_o.msg_acc  = 1'b1;
        OP_ENSEL:  evt_o.en_sel   = 1'b1;
        OP_DISSEL: evt_o.dis_sel  = 1'b1;
        default:   ;
      endcase
    end
    // per-byte interrupt only in non-DMA transfer mode
    evt_o.fifo_ti = reg_wr_i && (reg_addr_i == ADDR_W'(A_FIFO))
                    && (cmd_q_i == {1'b0, OP_XFER});
    evt_o.rd_intr = reg_rd_i && (reg_addr_i == ADDR_W'(A_INTR));
  end
endmodule

// File: rtl/scsi_irq_int_unit.sv
module scsi_irq_int_unit
  import scsi_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cmd_evt_t      evt_i,
  input  logic          ev_fc_i,
  input  logic          ev_bs_i,
  input  logic          ev_dc_i,
  input  logic          ev_busrst_i,
  input  logic          ev_tc_i,
  input  logic          norpt_i,
  output logic [DW-1:0] intr_o,
  output logic          int_o,
  output logic          tc_o,
  output logic          raise_o
);
  logic [N_IB-1:0] set_bits;
  logic [N_IB-1:0] intr_q;
  logic            int_q, tc_q, clr_intr;

  always_comb begin
    set_bits         = '0;
    set_bits[IB_FC]  = ev_fc_i | evt_i.fifo_ti;
    set_bits[IB_BS]  = ev_bs_i | evt_i.fifo_ti;
    set_bits[IB_DC]  = ev_dc_i | evt_i.msg_acc;
    set_bits[IB_RST] = (ev_busrst_i | evt_i.bus_rst) & ~norpt_i;
    raise_o  = (|set_bits) | evt_i.dis_sel;
    clr_intr = evt_i.rd_intr | evt_i.en_sel | evt_i.dis_sel;
  end

  // set wins over clear: a same-cycle event survives the acknowledge
  for (genvar b = 0; b < N_IB; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             intr_q[b] <= 1'b0;
      else if (evt_i.soft_rst) intr_q[b] <= 1'b0;
      else if (set_bits[b])    intr_q[b] <= 1'b1;
      else if (clr_intr)       intr_q[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= 1'b0;
      tc_q  <= 1'b0;
    end else if (evt_i.soft_rst) begin
      int_q <= 1'b0;
      tc_q  <= 1'b0;
    end else begin
      if (raise_o)            int_q <= 1'b1;
      else if (evt_i.rd_intr) int_q <= 1'b0;
      if (ev_tc_i)            tc_q  <= 1'b1;
      else if (evt_i.rd_intr) tc_q  <= 1'b0;
    end
  end

  assign intr_o = {{(DW-N_IB){1'b0}}, intr_q};
  assign int_o  = int_q;
  assign tc_o   = tc_q;
endmodule

// File: rtl/scsi_irq_rdmux.sv
module scsi_irq_rdmux
  import scsi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned PHASE_W = 3,
  parameter int unsigned SEQ_W   = 3,
  parameter int unsigned FLAGS_W = 5
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               int_i,
  input  logic               tc_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [DW-1:0]      intr_i,
  input  logic [SEQ_W-1:0]   seq_i,
  input  logic [FLAGS_W-1:0] flags_i,
  input  logic [DW-1:0]      cmd_i,
  input  logic [DW-1:0]      cfg1_i,
  output logic [DW-1:0]      data_o
);
  logic [DW-1:0] stat;

  always_comb begin
    stat              = '0;
    stat[SB_INT]      = int_i;
    stat[SB_TC]       = tc_i;
    stat[PHASE_W-1:0] = phase_i;
    unique case (addr_i)
      ADDR_W'(A_STAT):  data_o = stat;
      ADDR_W'(A_INTR):  data_o = intr_i;
      ADDR_W'(A_SEQ):   data_o = DW'(seq_i);
      ADDR_W'(A_FLAGS): data_o = DW'(flags_i);
      ADDR_W'(A_CMD):   data_o = cmd_i;
      ADDR_W'(A_CFG1):  data_o = cfg1_i;
      default:          data_o = '0;
    endcase
  end
endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
  import scsi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned PHASE_W = 3,
  parameter int unsigned SEQ_W   = 3,
  parameter int unsigned FLAGS_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  input  logic               ev_fc_i,
  input  logic               ev_bs_i,
  input  logic               ev_dc_i,
  input  logic               ev_busrst_i,
  input  logic               ev_tc_i,
  input  logic               phase_we_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               seq_we_i,
  input  logic [SEQ_W-1:0]   seq_i,
  input  logic               flags_we_i,
  input  logic [FLAGS_W-1:0] flags_i,
  input  logic               drq_set_i,
  input  logic               drq_clr_i,
  output logic               irq_o,
  output logic               drq_o
);
  cmd_evt_t           evt;
  logic [DW-1:0]      intr_q, cmd_q, cfg1_q, rd_mux, rdata_q;
  logic [PHASE_W-1:0] phase_q;
  logic [SEQ_W-1:0]   seq_q;
  logic [FLAGS_W-1:0] flags_q;
  logic               int_w, tc_w, raise_w, drq_q;

  scsi_irq_dec #(.ADDR_W(ADDR_W)) u_dec (
    .reg_wr_i   (reg_wr_i),
    .reg_rd_i   (reg_rd_i),
    .reg_addr_i (reg_addr_i),
    .op_i       (reg_wdata_i[6:0]),
    .cmd_q_i    (cmd_q),
    .evt_o      (evt)
  );

  scsi_irq_int_unit u_int (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .ev_fc_i     (ev_fc_i),
    .ev_bs_i     (ev_bs_i),
    .ev_dc_i     (ev_dc_i),
    .ev_busrst_i (ev_busrst_i),
    .ev_tc_i     (ev_tc_i),
    .norpt_i     (cfg1_q[CFG1_NORPT]),
    .intr_o      (intr_q),
    .int_o       (int_w),
    .tc_o        (tc_w),
    .raise_o     (raise_w)
  );

  scsi_irq_rdmux #(
    .ADDR_W(ADDR_W), .PHASE_W(PHASE_W), .SEQ_W(SEQ_W), .FLAGS_W(FLAGS_W)
  ) u_rdmux (
    .addr_i  (reg_addr_i),
    .int_i   (int_w),
    .tc_i    (tc_w),
    .phase_i (phase_q),
    .intr_i  (intr_q),
    .seq_i   (seq_q),
    .flags_i (flags_q),
    .cmd_i   (cmd_q),
    .cfg1_i  (cfg1_q),
    .data_o  (rd_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      seq_q   <= '0;
      flags_q <= '0;
      cmd_q   <= '0;
      cfg1_q  <= CFG1_INIT;
      drq_q   <= 1'b0;
    end else if (evt.soft_rst) begin
      phase_q <= '0;
      seq_q   <= '0;
      flags_q <= '0;
      cmd_q   <= '0;
      cfg1_q  <= CFG1_INIT;
      drq_q   <= 1'b0;
    end else begin
      if (phase_we_i) phase_q <= phase_i;
      if (seq_we_i)                        seq_q <= seq_i;
      else if (evt.rd_intr || evt.msg_acc) seq_q <= '0;
      if (flags_we_i)       flags_q <= flags_i;
      else if (evt.msg_acc) flags_q <= '0;
      if (reg_wr_i && reg_addr_i == ADDR_W'(A_CMD))  cmd_q  <= reg_wdata_i;
      if (reg_wr_i && reg_addr_i == ADDR_W'(A_CFG1)) cfg1_q <= reg_wdata_i;
      if (drq_set_i)      drq_q <= 1'b1;
      else if (drq_clr_i) drq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = int_w;
  assign drq_o       = drq_q;
endmodule

// File: rtl/scsi_irq_status_chk.sv
module scsi_irq_status_chk
  import scsi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned SEQ_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              seq_we_i,
  input logic              ev_fc_i,
  input logic              ev_busrst_i,
  input logic              irq_o,
  input logic              drq_o,
  input logic [DW-1:0]     intr_q,
  input logic [SEQ_W-1:0]  seq_q,
  input logic [DW-1:0]     cfg1_q,
  input logic              raise_w,
  input cmd_evt_t          evt
);
  // R1
  irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt.rd_intr && !raise_w && !evt.soft_rst) |=> !irq_o);

  // R1
  irq_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(raise_w));

  // R2
  seq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt.rd_intr && !seq_we_i) |=> (seq_q == '0));

  // R3
  evt_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_fc_i && !evt.soft_rst) |=> (intr_q[IB_FC] && irq_o));

  // R5
  busrst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt.bus_rst && !cfg1_q[CFG1_NORPT]) |=> (intr_q[IB_RST] && irq_o));

  // R5
  norpt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt.bus_rst && cfg1_q[CFG1_NORPT] && !ev_busrst_i && !evt.rd_intr)
      |=> $stable(intr_q[IB_RST]));

  // R8
  ti_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt.fifo_ti && !evt.soft_rst) |=> (intr_q[IB_BS] && intr_q[IB_FC] && irq_o));

  // R9
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt.soft_rst |=> (!irq_o && !drq_o && cfg1_q == CFG1_INIT));
endmodule

bind scsi_irq_status scsi_irq_status_chk #(.ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .seq_we_i    (seq_we_i),
  .ev_fc_i     (ev_fc_i),
  .ev_busrst_i (ev_busrst_i),
  .irq_o       (irq_o),
  .drq_o       (drq_o),
  .intr_q      (intr_q),
  .seq_q       (seq_q),
  .cfg1_q      (cfg1_q),
  .raise_w     (raise_w),
  .evt         (evt)
);

// File: tb/sim_scsi_irq_status.sv
module sim_scsi_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       ev_fc = 0, ev_bs = 0, ev_dc = 0, ev_busrst = 0, ev_tc = 0;
  logic       phase_we = 0, seq_we = 0, flags_we = 0, drq_set = 0, drq_clr = 0;
  logic [2:0] phase = 0, seq = 0;
  logic [4:0] flags = 0;
  logic       irq, drq;
  int         errors = 0, checks = 0;
  logic [7:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_irq_status u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .ev_fc_i(ev_fc), .ev_bs_i(ev_bs), .ev_dc_i(ev_dc), .ev_busrst_i(ev_busrst),
    .ev_tc_i(ev_tc), .phase_we_i(phase_we), .phase_i(phase), .seq_we_i(seq_we),
    .seq_i(seq), .flags_we_i(flags_we), .flags_i(flags), .drq_set_i(drq_set),
    .drq_clr_i(drq_clr), .irq_o(irq), .drq_o(drq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_rd = 1; reg_addr = a;
    step();
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic evts(input logic [2:0] m);
    ev_fc = m[0]; ev_bs = m[1]; ev_dc = m[2];
    step();
    ev_fc = 0; ev_bs = 0; ev_dc = 0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_ni = 1;
    step();
    // R9 hard reset state
    chk("R9 irq", {7'd0, irq}, 8'h00);
    chk("R9 drq", {7'd0, drq}, 8'h00);
    rd(3'd0, v); chk("R9 stat", v, 8'h00);
    rd(3'd1, v); chk("R9 intr", v, 8'h00);
    rd(3'd2, v); chk("R9 seq", v, 8'h00);
    rd(3'd3, v); chk("R9 flags", v, 8'h00);
    rd(3'd4, v); chk("R9 cmd", v, 8'h00);
    rd(3'd6, v); chk("R9 cfg1", v, 8'h07);

    // R3 / R1 / R2 sweep of event combinations
    for (int m = 1; m < 8; m++) begin
      evts(3'(m));
      chk("R1 irq raised", {7'd0, irq}, 8'h01);
      rd(3'd0, v); chk("R1 stat int", v, 8'h80);
      rd(3'd1, v); chk("R3 intr bits", v, 8'(m));
      chk("R2 irq lowered", {7'd0, irq}, 8'h00);
      rd(3'd1, v); chk("R2 intr cleared", v, 8'h00);
    end

    // R3 event in same cycle as acknowledge; R2 seq clear
    seq_we = 1; seq = 3'd5; step(); seq_we = 0;
    evts(3'b001);
    reg_rd = 1; reg_addr = 3'd1; ev_bs = 1;
    step();
    reg_rd = 0; ev_bs = 0; v = reg_rdata;
    chk("R3 read returns old", v, 8'h01);
    chk("R3 irq kept", {7'd0, irq}, 8'h01);
    rd(3'd2, v); chk("R2 seq cleared", v, 8'h00);
    rd(3'd1, v); chk("R3 late event kept", v, 8'h02);
    chk("R2 irq low", {7'd0, irq}, 8'h00);

    // R10 engine load wins over clear
    reg_rd = 1; reg_addr = 3'd1; seq_we = 1; seq = 3'd6;
    step();
    reg_rd = 0; seq_we = 0;
    rd(3'd2, v); chk("R10 seq load wins", v, 8'h06);

    // R4 transfer count
    ev_tc = 1; step(); ev_tc = 0;
    chk("R4 no irq", {7'd0, irq}, 8'h00);
    rd(3'd0, v); chk("R4 tc set", v, 8'h10);
    rd(3'd1, v);
    rd(3'd0, v); chk("R2 tc cleared", v, 8'h00);
    reg_rd = 1; reg_addr = 3'd1; ev_tc = 1;
    step();
    reg_rd = 0; ev_tc = 0;
    rd(3'd0, v); chk("R4 tc wins", v, 8'h10);
    rd(3'd1, v);

    // R10 phase / seq / flags sweeps
    for (int p = 0; p < 8; p++) begin
      phase_we = 1; phase = 3'(p); step(); phase_we = 0;
      rd(3'd0, v); chk("R10 phase", v, 8'(p));
      seq_we = 1; seq = 3'(7 - p); step(); seq_we = 0;
      rd(3'd2, v); chk("R10 seq", v, 8'(7 - p));
      flags_we = 1; flags = 5'(p * 4 + 3); step(); flags_we = 0;
      rd(3'd3, v); chk("R10 flags", v, 8'(p * 4 + 3));
    end
    phase_we = 1; phase = 0; step(); phase_we = 0;

    // R5 bus reset with reporting on and off
    wr(3'd4, 8'h03);
    chk("R5 irq", {7'd0, irq}, 8'h01);
    rd(3'd1, v); chk("R5 intr rst", v, 8'h08);
    wr(3'd6, 8'h47);
    rd(3'd6, v); chk("R12 cfg1 readback", v, 8'h47);
    wr(3'd4, 8'h03);
    chk("R5 suppressed irq", {7'd0, irq}, 8'h00);
    ev_busrst = 1; step(); ev_busrst = 0;
    chk("R5 suppressed event", {7'd0, irq}, 8'h00);
    rd(3'd1, v); chk("R5 suppressed intr", v, 8'h00);
    wr(3'd6, 8'h07);
    ev_busrst = 1; step(); ev_busrst = 0;
    rd(3'd1, v); chk("R5 event intr", v, 8'h08);

    // R6 selection commands
    evts(3'b001);
    wr(3'd4, 8'h44);
    chk("R6 ensel keeps irq", {7'd0, irq}, 8'h01);
    rd(3'd1, v); chk("R6 ensel cleared", v, 8'h00);
    wr(3'd4, 8'h44);
    chk("R6 ensel no raise", {7'd0, irq}, 8'h00);
    evts(3'b100);
    wr(3'd4, 8'h45);
    chk("R6 dissel irq", {7'd0, irq}, 8'h01);
    rd(3'd1, v); chk("R6 dissel cleared", v, 8'h00);
    wr(3'd4, 8'h45);
    chk("R6 dissel raises", {7'd0, irq}, 8'h01);
    rd(3'd1, v); chk("R6 dissel intr zero", v, 8'h00);

    // R7 message accepted
    seq_we = 1; seq = 3'd6; flags_we = 1; flags = 5'h1f; step();
    seq_we = 0; flags_we = 0;
    wr(3'd4, 8'h12);
    chk("R7 irq", {7'd0, irq}, 8'h01);
    rd(3'd2, v); chk("R7 seq", v, 8'h00);
    rd(3'd3, v); chk("R7 flags", v, 8'h00);
    rd(3'd1, v); chk("R7 intr", v, 8'h04);

    // R8 per-byte interrupt in non-DMA transfer only
    wr(3'd4, 8'h10);
    rd(3'd4, v); chk("R12 cmd readback", v, 8'h10);
    wr(3'd5, 8'haa);
    chk("R8 irq", {7'd0, irq}, 8'h01);
    rd(3'd1, v); chk("R8 intr", v, 8'h03);
    wr(3'd4, 8'h90);
    wr(3'd5, 8'h55);
    chk("R8 dma no irq", {7'd0, irq}, 8'h00);
    rd(3'd1, v); chk("R8 dma intr", v, 8'h00);

    // R11 data request
    drq_set = 1; step(); drq_set = 0;
    chk("R11 drq set", {7'd0, drq}, 8'h01);
    drq_clr = 1; step(); drq_clr = 0;
    chk("R11 drq clr", {7'd0, drq}, 8'h00);

    // R9 soft reset
    evts(3'b011);
    drq_set = 1; step(); drq_set = 0;
    wr(3'd6, 8'h55);
    seq_we = 1; seq = 3'd3; step(); seq_we = 0;
    wr(3'd4, 8'h02);
    chk("R9 soft irq", {7'd0, irq}, 8'h00);
    chk("R9 soft drq", {7'd0, drq}, 8'h00);
    rd(3'd6, v); chk("R9 soft cfg1", v, 8'h07);
    rd(3'd2, v); chk("R9 soft seq", v, 8'h00);
    rd(3'd1, v); chk("R9 soft intr", v, 8'h00);
    rd(3'd4, v); chk("R9 soft cmd", v, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule